// File: doc/BRIEF.md
# Chirp Frequency Ramp Generator

This block drives the 48-bit frequency tuning word of a numerically controlled oscillator so that the frequency can move over time. A rate timer runs on the system clock. Each time the timer expires, a signed delta word is applied to a running frequency register. That register starts from the first tuning word, so the output is always the start word plus the sum of the steps taken so far.

A 2-bit mode input selects the behaviour. In fixed mode the output simply follows the first tuning word. In chirp mode the output sweeps without bound. A single control pin freezes the sweep, and the rate timer freezes with it, so a resumed sweep keeps its cadence. In ramped FSK mode the same pin chooses which of two tuning words is the destination. The output then ramps toward that word in steps the size of the delta magnitude, and it stops exactly on the word without passing it. A clear control returns the output to the start word on the next clock in every mode.

Top module: `chirp_ramp_gen`

## Requirements
- R1: While `rst_n` is low, `ftw_o` is 0.
- R2: With `mode_i` = 2'b00 (fixed) or 2'b11 (spare, treated as fixed), `ftw_o` equals `tw1_i` one clock later. `ctl_pin_i` and `delta_i` have no effect, and the rate timer is held loaded with `rate_i`.
- R3: In chirp mode (`mode_i` = 2'b01), each step adds `delta_i`, read as a two's-complement value, to `ftw_o` modulo 2^FW. A negative delta therefore wraps below zero.
- R4: With `rate_i` = N, steps occur once every N+1 clocks. The first step lands N+1 clocks after leaving fixed mode or after a clear. With N = 0 there is a step on every clock.
- R5: In chirp mode, `ctl_pin_i` high freezes both `ftw_o` and the rate timer. When the pin goes low, the count left over from before the hold runs out before the next step, so no interval is cut short.
- R6: In ramped FSK mode (`mode_i` = 2'b10), the destination is `tw1_i` when `ctl_pin_i` is low and `tw2_i` when it is high. `ftw_o` moves toward the destination by the magnitude of `delta_i` at the R4 cadence, and in this mode the pin does not hold the sweep.
- R7: In ramped FSK mode, `ftw_o` never passes the destination. A step that would reach or cross it lands exactly on it, and the output stays there.
- R8: `clr_acc_i` high sets `ftw_o` to `tw1_i` on the next clock and reloads the rate timer, whatever the mode and even during a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 fixed, 01 chirp, 10 ramped FSK, 11 fixed |
| tw1_i | input | FW | Start tuning word, and the low-pin FSK destination |
| tw2_i | input | FW | High-pin FSK destination |
| delta_i | input | FW | Signed step word |
| rate_i | input | RW | Rate timer reload value |
| clr_acc_i | input | 1 | Return the output to the start word |
| ctl_pin_i | input | 1 | Hold in chirp mode, destination select in ramped FSK |
| ftw_o | output | FW | Frequency tuning word |

## Verification
The bench builds the block with FW = 48, the full tuning-word width, so the wrap of a negative chirp step below zero is checked on the real 48-bit boundary. It sets RW = 8, which keeps the rate values small: the N+1 cadence, a hold placed partway through an interval, and FSK stepping at rate 0 and rate 2 can all be counted exactly in a short run. The FSK destinations are chosen so that the gap is not a whole number of steps, which forces the clamp on arrival.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED = 2'b00,
        MODE_CHIRP = 2'b01,
        MODE_RFSK  = 2'b10,
        MODE_SPARE = 2'b11
    } sweep_mode_e;

endpackage

// File: rtl/chirp_rate_timer.sv
module chirp_rate_timer #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rate_i,
    input  logic          load_i,
    input  logic          run_i,
    output logic          tick_o
);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (load_i) begin
            st_d.cnt = rate_i;
        end else if (run_i) begin
            if (st_q.cnt == '0) begin
                tick_o   = 1'b1;
                st_d.cnt = rate_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a nonzero reload value forbids back-to-back ticks
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && rate_i != '0 && !load_i) |=> !tick_o);

    // R5: a stopped timer cannot tick
    assert_stopped_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i) |-> !tick_o);

endmodule

// File: rtl/chirp_step_unit.sv
module chirp_step_unit
    import chirp_pkg::*;
#(
    parameter int FW = 48
) (
    input  sweep_mode_e   mode_i,
    input  logic          restart_i,
    input  logic          tick_i,
    input  logic          pin_i,
    input  logic [FW-1:0] word_i,
    input  logic [FW-1:0] tw1_i,
    input  logic [FW-1:0] tw2_i,
    input  logic [FW-1:0] delta_i,
    output logic [FW-1:0] target_o,
    output logic [FW-1:0] word_o
);

    logic [FW-1:0] mag;
    logic [FW-1:0] gap;
    logic          below;
    logic [FW-1:0] fsk_next;

    always_comb begin
        mag      = delta_i[FW-1] ? (~delta_i + 1'b1) : delta_i;
        target_o = pin_i ? tw2_i : tw1_i;
        below    = (word_i < target_o);
        gap      = below ? (target_o - word_i) : (word_i - target_o);
        if (gap <= mag) begin
            fsk_next = target_o;
        end else if (below) begin
            fsk_next = word_i + mag;
        end else begin
            fsk_next = word_i - mag;
        end
    end

    always_comb begin
        word_o = word_i;
        if (restart_i) begin
            word_o = tw1_i;
        end else if (tick_i) begin
            unique case (mode_i)
                MODE_CHIRP: word_o = word_i + delta_i;
                MODE_RFSK:  word_o = fsk_next;
                default:    word_o = tw1_i;
            endcase
        end
    end

endmodule

// File: rtl/chirp_ramp_gen.sv
module chirp_ramp_gen
    import chirp_pkg::*;
#(
    parameter int FW = 48,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [FW-1:0] tw1_i,
    input  logic [FW-1:0] tw2_i,
    input  logic [FW-1:0] delta_i,
    input  logic [RW-1:0] rate_i,
    input  logic          clr_acc_i,
    input  logic          ctl_pin_i,
    output logic [FW-1:0] ftw_o
);

    typedef struct packed {
        logic [FW-1:0] word;
    } gen_state_t;

    gen_state_t    st_d, st_q;
    sweep_mode_e   mode;
    logic          fixed_mode;
    logic          hold;
    logic          restart;
    logic          tick;
    logic [FW-1:0] target;
    logic [FW-1:0] word_next;

    assign mode       = sweep_mode_e'(mode_i);
    assign fixed_mode = (mode == MODE_FIXED) || (mode == MODE_SPARE);
    assign hold       = (mode == MODE_CHIRP) && ctl_pin_i;
    assign restart    = clr_acc_i || fixed_mode;

    chirp_rate_timer #(.RW(RW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (rate_i),
        .load_i (restart),
        .run_i  (!hold),
        .tick_o (tick)
    );

    chirp_step_unit #(.FW(FW)) u_step (
        .mode_i    (mode),
        .restart_i (restart),
        .tick_i    (tick),
        .pin_i     (ctl_pin_i),
        .word_i    (st_q.word),
        .tw1_i     (tw1_i),
        .tw2_i     (tw2_i),
        .delta_i   (delta_i),
        .target_o  (target),
        .word_o    (word_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.word = word_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ftw_o = st_q.word;

    // R2: fixed modes follow the start word one clock later
    assert_fixed_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_mode |=> (ftw_o == $past(tw1_i)));

    // R5: chirp hold keeps the output still
    assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr_acc_i) |=> $stable(ftw_o));

    // R7: an FSK ramp from below never ends above its destination
    assert_no_overshoot_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RFSK && !clr_acc_i && ftw_o <= target) |=> (ftw_o <= $past(target)));

    // R7: an FSK ramp from above never ends below its destination
    assert_no_overshoot_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RFSK && !clr_acc_i && ftw_o >= target) |=> (ftw_o >= $past(target)));

    // R8: clear returns to the start word
    assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc_i |=> (ftw_o == $past(tw1_i)));

endmodule

// File: tb/chirp_ramp_gen_tb.sv
module chirp_ramp_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 48;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [FW-1:0] tw1_i = '0;
    logic [FW-1:0] tw2_i = '0;
    logic [FW-1:0] delta_i = '0;
    logic [RW-1:0] rate_i = '0;
    logic          clr_acc_i = 1'b0;
    logic          ctl_pin_i = 1'b0;
    logic [FW-1:0] ftw_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chirp_ramp_gen #(.FW(FW), .RW(RW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .tw1_i     (tw1_i),
        .tw2_i     (tw2_i),
        .delta_i   (delta_i),
        .rate_i    (rate_i),
        .clr_acc_i (clr_acc_i),
        .ctl_pin_i (ctl_pin_i),
        .ftw_o     (ftw_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [FW-1:0] exp);
        n_checks++;
        if (ftw_o !== exp) begin
            n_fail++;
            $display("FAIL %s: ftw_o actual %0d expected %0d", req, ftw_o, exp);
        end
    endtask

    // put the block in fixed mode on a start word so the timer holds rate_i
    task automatic park(input logic [FW-1:0] start, input logic [RW-1:0] rate,
                        input logic [FW-1:0] delta);
        mode_i    = 2'b00;
        ctl_pin_i = 1'b0;
        clr_acc_i = 1'b0;
        tw1_i     = start;
        rate_i    = rate;
        delta_i   = delta;
        tick(2);
    endtask

    task automatic t_reset;
        tw1_i = 48'd777;
        tick(3);
        check("R1", '0);
        rst_n = 1'b1;
    endtask

    task automatic t_fixed;
        park(48'h1234_5678_9ABC, 8'd3, 48'd99);
        check("R2", 48'h1234_5678_9ABC);
        ctl_pin_i = 1'b1;
        delta_i   = 48'd5000;
        tick(4);
        check("R2", 48'h1234_5678_9ABC);
        mode_i = 2'b11;
        tw1_i  = 48'd42;
        tick(1);
        check("R2", 48'd42);
        ctl_pin_i = 1'b0;
    endtask

    task automatic t_cadence;
        park(48'd1000, 8'd5, 48'd30);
        mode_i = 2'b01;
        tick(5);
        check("R4", 48'd1000);
        tick(1);
        check("R3", 48'd1030);
        tick(5);
        check("R4", 48'd1030);
        tick(1);
        check("R4", 48'd1060);
        park(48'd1000, 8'd0, 48'd30);
        mode_i = 2'b01;
        tick(1);
        check("R4", 48'd1030);
        tick(1);
        check("R4", 48'd1060);
    endtask

    task automatic t_hold;
        park(48'd500, 8'd5, 48'd11);
        mode_i = 2'b01;
        tick(2);
        ctl_pin_i = 1'b1;
        tick(20);
        check("R5", 48'd500);
        ctl_pin_i = 1'b0;
        tick(3);
        check("R5", 48'd500);
        tick(1);
        check("R5", 48'd511);
    endtask

    task automatic t_wrap;
        park(48'd50, 8'd0, -48'sd100);
        mode_i = 2'b01;
        tick(1);
        check("R3", 48'hFFFF_FFFF_FFCE);
        tick(1);
        check("R3", 48'hFFFF_FFFF_FF6A);
    endtask

    task automatic t_fsk(input logic [FW-1:0] delta);
        park(48'd1000, 8'd0, delta);
        tw2_i     = 48'd1250;
        mode_i    = 2'b10;
        ctl_pin_i = 1'b1;
        tick(1);
        check("R6", 48'd1100);
        tick(1);
        check("R6", 48'd1200);
        tick(1);
        check("R7", 48'd1250);
        tick(3);
        check("R7", 48'd1250);
        ctl_pin_i = 1'b0;
        tick(1);
        check("R6", 48'd1150);
        tick(1);
        check("R6", 48'd1050);
        tick(1);
        check("R7", 48'd1000);
        tick(2);
        check("R7", 48'd1000);
    endtask

    task automatic t_fsk_rate;
        park(48'd1000, 8'd2, 48'd100);
        tw2_i     = 48'd1250;
        mode_i    = 2'b10;
        ctl_pin_i = 1'b1;
        tick(2);
        check("R6", 48'd1000);
        tick(1);
        check("R6", 48'd1100);
    endtask

    task automatic t_clear;
        park(48'd2000, 8'd0, 48'd7);
        mode_i = 2'b01;
        tick(3);
        check("R3", 48'd2021);
        ctl_pin_i = 1'b1;
        clr_acc_i = 1'b1;
        tick(1);
        check("R8", 48'd2000);
        clr_acc_i = 1'b0;
        tick(1);
        check("R8", 48'd2000);
        ctl_pin_i = 1'b0;
        tick(1);
        check("R8", 48'd2007);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_fixed();
        t_cadence();
        t_hold();
        t_wrap();
        t_fsk(48'd100);
        t_fsk(-48'sd100);
        t_fsk_rate();
        t_clear();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule